// File: doc/BRIEF.md
# Manchester Fieldbus Frame Transmitter

This block sends one fieldbus frame on a single serial line and drives a transmit-enable output alongside it. The host first sets up a control byte, a payload buffer and a payload byte count, and then gives a one-cycle start pulse. The block then sends the whole frame in Manchester code. The frame holds a preamble, a start delimiter, the control byte, the payload bytes, a 16-bit CRC and an end delimiter.

The bit rate comes from a 2-bit speed code that is sampled at start. Each code selects a half-bit cell length, counted in system clocks. The block reads the payload buffer through a word address output and a 32-bit data input, and the data input must be valid in the same cycle. While the frame is on the line, the block shows the index of the byte being sent. One cycle after the last cell has gone out, it gives a single-cycle done pulse. A synchronous abort input drops any frame in progress and returns the block to idle.

Top module: `fbus_frame_tx`

## Requirements
- R1: The speed code selects the half-bit cell length: 0 gives HALF_S0, 1 gives HALF_S1, 2 gives HALF_S2 and 3 gives HALF_S3 clocks. A bit lasts two cells. The code is sampled at start, and later changes have no effect until the next frame. The defaults give 31.25 kbit/s, 1, 2.5 and 5 Mbit/s on a 100 MHz clock.
- R2: Every frame element lasts 8 bit times, sent in this order:
  - preamble: bits 1,0,1,0,1,0,1,0
  - start delimiter: 1,H,L,1,0,L,H,0
  - control byte
  - each payload byte
  - CRC high byte
  - CRC low byte
  - end delimiter: 1,H,L,H,L,1,0,1

  Data bit 1 is sent as a high cell then a low cell, and bit 0 as low then high. H is two high cells and L is two low cells. Bytes go out MSB first.
- R3: The CRC is 16 bits with polynomial CRC_POLY (default 16'h1DCF), processed MSB first, without reflection. It starts at 16'hFFFF and covers the control byte and then the payload bytes. It is sent bitwise inverted, high byte first.
- R4: At start the block samples the byte count and the control byte. A count above MAX_PAY (default 262, so 263 frame bytes with the control byte) is treated as MAX_PAY. Later changes to either input, and start pulses while a frame is in progress, have no effect on the frame.
- R5: The byte index is 0 from start through the control byte. It is k for payload byte k (1-based), N+1 for the CRC high byte, and N+2 for the CRC low byte and the end delimiter. Here N is the sampled count. It holds that value after the frame.
- R6: The done output is a single-cycle pulse in the first cycle after tx_en falls at the end of a completed frame.
- R7: tx_en rises on the clock edge that samples start. It stays high for exactly (N+6)×16×half clocks.
- R8: tx_data is low whenever tx_en is low.
- R9: tx_abort in a cycle ends the frame. In the next cycle tx_en and tx_data are low, the index is 0, and no done pulse follows.
- R10: Payload byte j is read from word address j/4, in bits [8·(j mod 4)+7 : 8·(j mod 4)].
- R11: After reset, tx_en, tx_data, tx_done and the index are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_abort | input | 1 | Synchronous abort of the frame in progress |
| start | input | 1 | Start pulse, ignored while busy |
| speed | input | 2 | Bit-rate code |
| byte_count | input | 16 | Number of payload bytes |
| ctrl_byte | input | 8 | Control byte |
| buf_addr | output | AW | Payload buffer word address |
| buf_word | input | 32 | Payload buffer word, valid in the same cycle |
| tx_data | output | 1 | Manchester serial line |
| tx_en | output | 1 | Transmit enable |
| tx_index | output | 16 | Index of the byte on the line |
| tx_done | output | 1 | End-of-frame pulse |

## Verification
The bench sweeps all four speed codes over payload counts from 0 to 9. It adds a full-length frame and a count above the limit, and it compares every clock of tx_data against a cell stream rebuilt from the symbol lists and a bit-serial CRC. Several errors would show up directly:
- A zero-payload frame that skipped straight to the end delimiter would lose the CRC bytes.
- A design that used the live count, or restarted on a second start, would produce a frame of the wrong length.
- An off-by-one in the cell timer would stretch every cell.

The abort case checks that a frame dropped mid-way gives no done pulse and leaves the line quiet.

// File: rtl/fbus_tx_pkg.sv
package fbus_tx_pkg;

  typedef enum logic [2:0] {
    SEG_PRE, SEG_SD, SEG_CTRL, SEG_DATA, SEG_CRCH, SEG_CRCL, SEG_ED
  } seg_e;

  // Cell patterns (first cell in bit 15) for the fixed frame elements.
  localparam logic [15:0] CELLS_PRE = 16'h9999;
  localparam logic [15:0] CELLS_SD  = 16'hB24D;
  localparam logic [15:0] CELLS_ED  = 16'hB326;

  // Manchester: a 1 is high-then-low, a 0 is low-then-high, MSB first.
  function automatic logic [15:0] manch(input logic [7:0] b);
    logic [15:0] c;
    for (int i = 0; i < 8; i++) begin
      c[2*i+1] = b[i];
      c[2*i]   = ~b[i];
    end
    return c;
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] crc,
                                           input logic [7:0]  b,
                                           input logic [15:0] poly);
    logic [15:0] r;
    r = crc ^ {b, 8'h00};
    for (int i = 0; i < 8; i++)
      r = r[15] ? ((r << 1) ^ poly) : (r << 1);
    return r;
  endfunction

endpackage

// File: rtl/fbus_cell_timer.sv
module fbus_cell_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [CW-1:0] half_len,
  output logic          cell_end
);
  logic [CW-1:0] cnt;

  assign cell_end = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (restart || cell_end) cnt <= half_len - CW'(1);
    else if (run)                 cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/fbus_cell_shift.sv
module fbus_cell_shift (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        load,
  input  logic [15:0] pat,
  input  logic        shift,
  output logic        line,
  output logic        last
);
  logic [15:0] sr;
  logic [3:0]  pos;

  assign line = sr[15];
  assign last = (pos == 4'd15);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sr  <= '0;
      pos <= '0;
    end else if (load) begin
      sr  <= pat;
      pos <= '0;
    end else if (shift) begin
      sr  <= {sr[14:0], 1'b0};
      pos <= pos + 4'd1;
    end
  end
endmodule

// File: rtl/fbus_crc16.sv
module fbus_crc16
  import fbus_tx_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h1DCF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n || init) crc <= 16'hFFFF;
    else if (upd)       crc <= crc_step(crc, din, POLY);
  end
endmodule

// File: rtl/fbus_frame_tx.sv
module fbus_frame_tx
  import fbus_tx_pkg::*;
#(
  parameter int          HALF_S0  = 1600,
  parameter int          HALF_S1  = 50,
  parameter int          HALF_S2  = 20,
  parameter int          HALF_S3  = 10,
  parameter int          MAX_PAY  = 262,
  parameter logic [15:0] CRC_POLY = 16'h1DCF,
  localparam int HMAX01 = (HALF_S0 > HALF_S1) ? HALF_S0 : HALF_S1,
  localparam int HMAX23 = (HALF_S2 > HALF_S3) ? HALF_S2 : HALF_S3,
  localparam int HMAX   = (HMAX01 > HMAX23) ? HMAX01 : HMAX23,
  localparam int CW     = $clog2(HMAX + 1),
  localparam int WORDS  = (MAX_PAY + 3) / 4,
  localparam int AW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_abort,
  input  logic          start,
  input  logic [1:0]    speed,
  input  logic [15:0]   byte_count,
  input  logic [7:0]    ctrl_byte,
  output logic [AW-1:0] buf_addr,
  input  logic [31:0]   buf_word,
  output logic          tx_data,
  output logic          tx_en,
  output logic [15:0]   tx_index,
  output logic          tx_done
);

  function automatic logic [CW-1:0] half_of(input logic [1:0] s);
    case (s)
      2'd0:    return CW'(HALF_S0);
      2'd1:    return CW'(HALF_S1);
      2'd2:    return CW'(HALF_S2);
      default: return CW'(HALF_S3);
    endcase
  endfunction

  logic        running, done_q;
  logic [1:0]  spd_q;
  logic [15:0] n_q, pay_cnt, idx_q, crc;
  logic [7:0]  ctrl_q;
  seg_e        seg, nxt_seg;

  // Named internal events for the checker and for readability.
  logic        go, cell_end, last_cell, seg_end, frame_end, upd_c;
  logic [7:0]  fetched, byte_now;
  logic [15:0] nxt_pat;

  assign go        = start && !running && !tx_abort;
  assign seg_end   = cell_end && last_cell;
  assign frame_end = seg_end && (seg == SEG_ED);
  assign fetched   = buf_word[{pay_cnt[1:0], 3'b000} +: 8];
  assign buf_addr  = pay_cnt[AW+1:2];

  always_comb begin
    nxt_seg  = seg;
    nxt_pat  = '0;
    byte_now = '0;
    upd_c    = 1'b0;
    case (seg)
      SEG_PRE: begin nxt_seg = SEG_SD; nxt_pat = CELLS_SD; end
      SEG_SD: begin
        nxt_seg = SEG_CTRL; byte_now = ctrl_q; nxt_pat = manch(ctrl_q); upd_c = 1'b1;
      end
      SEG_CTRL, SEG_DATA: begin
        if (pay_cnt < n_q) begin
          nxt_seg = SEG_DATA; byte_now = fetched; nxt_pat = manch(fetched); upd_c = 1'b1;
        end else begin
          nxt_seg = SEG_CRCH; nxt_pat = manch(~crc[15:8]);
        end
      end
      SEG_CRCH: begin nxt_seg = SEG_CRCL; nxt_pat = manch(~crc[7:0]); end
      SEG_CRCL: begin nxt_seg = SEG_ED; nxt_pat = CELLS_ED; end
      default:  nxt_seg = SEG_ED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0; done_q <= 1'b0; spd_q <= '0; n_q <= '0;
      ctrl_q <= '0; pay_cnt <= '0; idx_q <= '0; seg <= SEG_PRE;
    end else begin
      done_q <= frame_end && !tx_abort;
      if (tx_abort) begin
        running <= 1'b0;
        idx_q   <= '0;
      end else if (go) begin
        running <= 1'b1;
        spd_q   <= speed;
        ctrl_q  <= ctrl_byte;
        n_q     <= (byte_count > 16'(MAX_PAY)) ? 16'(MAX_PAY) : byte_count;
        pay_cnt <= '0;
        idx_q   <= '0;
        seg     <= SEG_PRE;
      end else if (seg_end) begin
        if (frame_end) running <= 1'b0;
        seg <= nxt_seg;
        if (nxt_seg == SEG_DATA) pay_cnt <= pay_cnt + 16'd1;
        if (seg inside {SEG_CTRL, SEG_DATA, SEG_CRCH}) idx_q <= idx_q + 16'd1;
      end
    end
  end

  fbus_cell_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (go),
    .run      (running),
    .half_len (go ? half_of(speed) : half_of(spd_q)),
    .cell_end (cell_end)
  );

  fbus_cell_shift u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tx_abort || frame_end),
    .load  (go || seg_end),
    .pat   (go ? CELLS_PRE : nxt_pat),
    .shift (cell_end && !last_cell),
    .line  (tx_data),
    .last  (last_cell)
  );

  fbus_crc16 #(.POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (go),
    .upd   (seg_end && upd_c && !tx_abort),
    .din   (byte_now),
    .crc   (crc)
  );

  assign tx_en    = running;
  assign tx_index = idx_q;
  assign tx_done  = done_q;

endmodule

// File: rtl/fbus_frame_tx_chk.sv
module fbus_frame_tx_chk #(
  parameter int MAX_PAY = 262
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_abort,
  input logic        tx_en,
  input logic        tx_data,
  input logic        tx_done,
  input logic [15:0] tx_index
);
  // R6: done comes right after tx_en drops
  a_r6_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!tx_en && $past(tx_en)));

  // R6: done lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R9: abort leaves the block idle with no done
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> (!tx_en && !tx_done && tx_index == 16'd0));

  // R5: index never passes the last CRC byte
  a_r5_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (tx_index <= 16'(MAX_PAY + 2)));

  // R5: index moves by at most one per cycle within a frame
  a_r5_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en)) |->
      (tx_index == $past(tx_index) || tx_index == $past(tx_index) + 16'd1));

  // R8: quiet line outside a frame
  a_r8_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_data);
endmodule

bind fbus_frame_tx fbus_frame_tx_chk #(.MAX_PAY(MAX_PAY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_abort (tx_abort),
  .tx_en    (tx_en),
  .tx_data  (tx_data),
  .tx_done  (tx_done),
  .tx_index (tx_index)
);

// File: tb/fbus_frame_tx_test.sv
module fbus_frame_tx_test;
  localparam int H0 = 4, H1 = 3, H2 = 2, H3 = 1;
  localparam int MAXP = 262;
  localparam logic [15:0] POLY = 16'h1DCF;
  localparam int AWT = 7;

  logic clk = 1'b0, rst_n = 1'b0, tx_abort = 1'b0, start = 1'b0;
  logic [1:0]  speed = '0;
  logic [15:0] byte_count = '0;
  logic [7:0]  ctrl_byte = '0;
  logic [AWT-1:0] buf_addr;
  logic [31:0] buf_word;
  logic tx_data, tx_en, tx_done;
  logic [15:0] tx_index;

  logic [31:0] mem [0:127];
  assign buf_word = mem[buf_addr];

  fbus_frame_tx #(.HALF_S0(H0), .HALF_S1(H1), .HALF_S2(H2), .HALF_S3(H3),
                  .MAX_PAY(MAXP), .CRC_POLY(POLY)) uut (
    .clk(clk), .rst_n(rst_n), .tx_abort(tx_abort), .start(start), .speed(speed),
    .byte_count(byte_count), .ctrl_byte(ctrl_byte), .buf_addr(buf_addr),
    .buf_word(buf_word), .tx_data(tx_data), .tx_en(tx_en), .tx_index(tx_index),
    .tx_done(tx_done));

  always #5 clk = ~clk;

  int vectors = 0, miss = 0, wd = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      vectors++; miss++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

  // expected cell stream
  logic exp_cell [0:8191];
  int exp_len;
  logic [15:0] ecrc;
  localparam int SD_SYM [8] = '{1, 2, 3, 1, 0, 3, 2, 0};
  localparam int ED_SYM [8] = '{1, 2, 3, 2, 3, 1, 0, 1};

  task automatic push_sym(input int code);
    // 0,1 data bits; 2 both-high violation; 3 both-low violation
    case (code)
      0: begin exp_cell[exp_len] = 0; exp_cell[exp_len+1] = 1; end
      1: begin exp_cell[exp_len] = 1; exp_cell[exp_len+1] = 0; end
      2: begin exp_cell[exp_len] = 1; exp_cell[exp_len+1] = 1; end
      default: begin exp_cell[exp_len] = 0; exp_cell[exp_len+1] = 0; end
    endcase
    exp_len += 2;
  endtask

  task automatic push_byte(input logic [7:0] b, input bit in_crc);
    for (int i = 7; i >= 0; i--) begin
      push_sym(b[i]);
      if (in_crc) begin
        logic fb;
        fb = ecrc[15] ^ b[i];
        ecrc = {ecrc[14:0], 1'b0};
        if (fb) ecrc = ecrc ^ POLY;
      end
    end
  endtask

  function automatic int halfof(input int s);
    return (s == 0) ? H0 : (s == 1) ? H1 : (s == 2) ? H2 : H3;
  endfunction

  function automatic logic [7:0] pbyte(input int j, input int n, input int s);
    return 8'(j * 37 + n * 11 + s * 3 + 5);
  endfunction

  // monitor
  int half_cur = 1, cur_n = 0;
  int mon_cyc, mon_err, mon_idx_err, mon_done, mon_done_bad;
  logic prev_en = 1'b0;

  always @(negedge clk) begin
    if (tx_en) begin
      if (mon_cyc / half_cur < exp_len) begin
        if (tx_data !== exp_cell[mon_cyc / half_cur]) mon_err++;
      end else mon_err++;
      if (mon_cyc % (16 * half_cur) == 0) begin
        int s, e;
        s = mon_cyc / (16 * half_cur);
        e = (s <= 2) ? 0 : (s <= cur_n + 4) ? s - 2 : cur_n + 2;
        if (tx_index !== 16'(e)) mon_idx_err++;
      end
      mon_cyc++;
    end
    if (tx_done) begin
      mon_done++;
      if (!prev_en || tx_en) mon_done_bad++;
    end
    prev_en = tx_en;
  end

  task automatic clear_mon();
    @(posedge clk);
    mon_cyc = 0; mon_err = 0; mon_idx_err = 0; mon_done = 0; mon_done_bad = 0;
  endtask

  task automatic prepare(input int s, input int n, output logic [7:0] c);
    half_cur = halfof(s);
    cur_n = (n > MAXP) ? MAXP : n;
    for (int j = 0; j < 512; j++) mem[j/4][8*(j%4) +: 8] = pbyte(j, n, s);
    c = 8'(n * 5 + s + 1);
    exp_len = 0; ecrc = 16'hFFFF;
    for (int k = 0; k < 8; k++) push_sym((k % 2 == 0) ? 1 : 0);
    for (int k = 0; k < 8; k++) push_sym(SD_SYM[k]);
    push_byte(c, 1);
    for (int j = 0; j < cur_n; j++) push_byte(pbyte(j, n, s), 1);
    push_byte(~ecrc[15:8], 0);
    push_byte(~ecrc[7:0], 0);
    for (int k = 0; k < 8; k++) push_sym(ED_SYM[k]);
  endtask

  // R1 R2 R3 R4 R5 R6 R7 R8 R10 checked per frame
  task automatic run_frame(input int s, input int n, input bit junk);
    logic [7:0] c;
    int k;
    prepare(s, n, c);
    clear_mon();
    @(negedge clk);
    speed = 2'(s); byte_count = 16'(n); ctrl_byte = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0; byte_count = 16'hFFFF; speed = ~2'(s); ctrl_byte = ~c;
    if (junk) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    k = 0;
    while (mon_done == 0 && k < 40000) begin @(negedge clk); k++; end
    @(negedge clk);
    chk(mon_cyc == exp_len * half_cur, junk ? "R4 restart ignored" : "R7/R1 frame length",
        mon_cyc, exp_len * half_cur);
    chk(mon_err == 0, "R2/R3/R10 cell stream", mon_err, 0);
    chk(mon_idx_err == 0, "R5 byte index", mon_idx_err, 0);
    chk(mon_done == 1 && mon_done_bad == 0, "R6 done pulse", mon_done, 1);
    chk(!tx_en && !tx_data, "R8 idle line", int'(tx_data), 0);
  endtask

  initial begin
    for (int j = 0; j < 128; j++) mem[j] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_en && !tx_data && !tx_done && tx_index == 0, "R11 reset state",
        int'({tx_en, tx_data, tx_done}), 0);

    for (int s = 0; s < 4; s++) begin
      run_frame(s, 0, 0);
      run_frame(s, 1, 0);
      run_frame(s, 2, 0);
      run_frame(s, 3, 0);
      run_frame(s, 4, 0);
      run_frame(s, 5, 1);
      run_frame(s, 9, 0);
    end
    run_frame(3, 262, 0);  // full-length frame
    run_frame(3, 300, 0);  // R4 clamp to MAX_PAY

    // R9 abort mid-frame
    begin
      logic [7:0] c;
      prepare(3, 4, c);
      clear_mon();
      @(negedge clk);
      speed = 2'd3; byte_count = 16'd4; ctrl_byte = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      tx_abort = 1'b1;
      @(negedge clk);
      tx_abort = 1'b0;
      chk(!tx_en && !tx_data && tx_index == 0, "R9 abort to idle",
          int'({tx_en, tx_data}), 0);
      repeat (200) @(negedge clk);
      chk(mon_done == 0 && !tx_en, "R9 no done after abort", mon_done, 0);
    end
    run_frame(2, 3, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule